// File: doc/BRIEF.md
# Shared High-Byte Bridge for 16-bit Registers

This block sits between an 8-bit processor bus and a group of 16-bit peripheral registers: one free-running counter, one capture register and a parameterised number of compare registers. The processor can only move one byte per access. Without help, the two halves of a changing 16-bit value could come from different moments. The bridge avoids this with a single 8-bit holding byte that every register in the group shares.

For a write, software first writes the high byte, which only loads the holding byte. It then writes the low byte, and the bridge issues one 16-bit write strobe that carries the holding byte and the low byte together. For a read of the counter or the capture register, software reads the low byte first. That access also copies the register's high half into the holding byte. A later read of the high address returns the holding byte, so both halves come from the same cycle. Compare registers are only written through the holding byte. Their bytes are read directly.

Top module: `byte16_bridge`

## Requirements
- R1: After reset the holding byte is 0x00, `cpuRdData` is 0x00, and no write strobe is active. A read of the counter high address (1) returns 0x00.
- R2: A write to any odd (high-byte) address inside the map changes only the holding byte and produces no write strobe. The map is: counter at 0/1, capture at 2/3, compare k at 4+2k/5+2k (even = low byte, odd = high byte).
- R3: A write to address 0 raises `cntWrEn` for exactly one cycle, in the cycle after the write. `wrData16` carries {holding byte, written byte}.
- R4: A write to address 4+2k raises only `cmpWrEn[k]` for one cycle, in the cycle after the write, with the same `wrData16` format. At most one strobe is active in any cycle.
- R5: A read of address 0 or 2 returns the low byte of that register in the cycle after the read. The same access loads the register's high byte into the holding byte.
- R6: A read of address 1 or 3 returns the holding byte.
- R7: A read of address 5+2k returns the high byte of compare k directly. A read of 4+2k returns its low byte. Neither read changes the holding byte.
- R8: The holding byte is shared. A value placed in it through any register's address is the one used by the next commit, or returned by the next holding-byte read, on any register.
- R9: A write to address 2 (capture low) produces no strobe and leaves the holding byte unchanged.
- R10: Addresses above the last high-byte address are ignored on write: no strobe and no holding-byte change. On read they return 0x00.
- R11: `cpuRdData` changes only after an accepted read. When `cpuRd` and `cpuWr` are both high in the same cycle, the write is performed and the read is ignored.
- R12: The counter is read low byte first, then high byte. The 16-bit value assembled from those two reads equals the counter value at the low-byte read, even when the counter carries into its high byte between the two reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWrData | input | 8 | Write byte |
| cpuWr | input | 1 | Write strobe, one cycle per access |
| cpuRd | input | 1 | Read strobe, one cycle per access |
| cpuRdData | output | 8 | Read byte, valid the cycle after `cpuRd` |
| cntVal | input | 16 | Current counter value |
| capVal | input | 16 | Current capture value |
| cmpVal | input | 16*NUM_CMP | Compare values, compare k at bits [16k+15:16k] |
| cntWrEn | output | 1 | Counter 16-bit write strobe |
| cmpWrEn | output | NUM_CMP | Compare 16-bit write strobes |
| wrData16 | output | 16 | Data for the active 16-bit write strobe |

## Verification
The hardest case is the torn read: the counter must carry from 0xFF into the next high byte exactly between the low-byte read and the high-byte read. The bench holds a counter model that takes the bridge's own commit strobe. It loads 0x12FF through the bridge while the counter is stopped. It then starts the counter in the same cycle as the low-byte read, so the carry falls right after the snapshot. The high-byte read must still return 0x12 while the live counter already shows 0x13. The shared nature of the holding byte is reached through cross-register sequences: a high write on one compare followed by a low write on another, and a capture snapshot read back through the counter's high address.

// File: rtl/byte16_bridge_pkg.sv
package byte16_bridge_pkg;
  localparam int IDX_W = 4;  // up to 16 registers in the group

  typedef enum logic [1:0] {
    RD_LOW  = 2'd0,
    RD_TEMP = 2'd1,
    RD_HIGH = 2'd2,
    RD_ZERO = 2'd3
  } rdSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic             tempWr;    // load holding byte from bus data
    logic             tempSnap;  // load holding byte from selected high half
    logic             rdEn;      // update read data register
    rdSelE            rdSel;
    logic             commit;    // issue 16-bit write
    logic [IDX_W-1:0] regIdx;    // 0 counter, 1 capture, 2.. compare
  } ctlS;
endpackage

// File: rtl/byte16_bridge_ctrl.sv
module byte16_bridge_ctrl
  import byte16_bridge_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CMP = 3
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  output ctlS               ctl
);
  localparam int NREG      = 2 + NUM_CMP;
  localparam int LAST_ADDR = 2 * NREG - 1;

  logic [ADDR_W-1:0] idxFull;
  logic inRange, isHigh, isCap, isCmp;

  always_comb begin
    idxFull = cpuAddr >> 1;
    inRange = cpuAddr <= ADDR_W'(LAST_ADDR);
    isHigh  = cpuAddr[0];
    isCap   = idxFull == ADDR_W'(1);
    isCmp   = idxFull >= ADDR_W'(2);

    ctl        = '0;
    ctl.rdSel  = RD_ZERO;
    ctl.regIdx = idxFull[IDX_W-1:0];

    if (cpuWr) begin
      // write wins over a simultaneous read
      if (inRange) begin
        if (isHigh)      ctl.tempWr = 1'b1;
        else if (!isCap) ctl.commit = 1'b1;
      end
    end else if (cpuRd) begin
      ctl.rdEn = 1'b1;
      if (!inRange) begin
        ctl.rdSel = RD_ZERO;
      end else if (!isHigh) begin
        ctl.rdSel    = RD_LOW;
        ctl.tempSnap = !isCmp;
      end else begin
        ctl.rdSel = isCmp ? RD_HIGH : RD_TEMP;
      end
    end
  end
endmodule

// File: rtl/byte16_bridge_dp.sv
module byte16_bridge_dp
  import byte16_bridge_pkg::*;
#(
  parameter int NUM_CMP = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlS                  ctl,
  input  logic [7:0]           wrByte,
  input  logic [16*(2+NUM_CMP)-1:0] regVals,
  output logic [7:0]           rdData,
  output logic                 cntWrEn,
  output logic [NUM_CMP-1:0]   cmpWrEn,
  output logic [15:0]          wrData16
);
  localparam int NREG = 2 + NUM_CMP;

  logic [7:0]  tempQ;
  logic [15:0] selVal;

  always_comb begin
    selVal = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ctl.regIdx == IDX_W'(i)) selVal = regVals[i*16 +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempQ    <= '0;
      rdData   <= '0;
      cntWrEn  <= 1'b0;
      wrData16 <= '0;
    end else begin
      if (ctl.tempWr)        tempQ <= wrByte;
      else if (ctl.tempSnap) tempQ <= selVal[15:8];

      if (ctl.rdEn) begin
        case (ctl.rdSel)
          RD_LOW:  rdData <= selVal[7:0];
          RD_TEMP: rdData <= tempQ;
          RD_HIGH: rdData <= selVal[15:8];
          default: rdData <= 8'h00;
        endcase
      end

      cntWrEn <= ctl.commit && (ctl.regIdx == IDX_W'(0));
      if (ctl.commit) wrData16 <= {tempQ, wrByte};
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmpStb
    always_ff @(posedge clk) begin
      if (!rstN) cmpWrEn[g] <= 1'b0;
      else       cmpWrEn[g] <= ctl.commit && (ctl.regIdx == IDX_W'(g + 2));
    end
  end
endmodule

// File: rtl/byte16_bridge.sv
module byte16_bridge
  import byte16_bridge_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CMP = 3   // 1..14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuWrData,
  input  logic                    cpuWr,
  input  logic                    cpuRd,
  output logic [7:0]              cpuRdData,
  input  logic [15:0]             cntVal,
  input  logic [15:0]             capVal,
  input  logic [16*NUM_CMP-1:0]   cmpVal,
  output logic                    cntWrEn,
  output logic [NUM_CMP-1:0]      cmpWrEn,
  output logic [15:0]             wrData16
);
  localparam int NREG      = 2 + NUM_CMP;
  localparam int LAST_ADDR = 2 * NREG - 1;

  ctlS ctl;

  byte16_bridge_ctrl #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_ctrl (
    .cpuAddr (cpuAddr),
    .cpuWr   (cpuWr),
    .cpuRd   (cpuRd),
    .ctl     (ctl)
  );

  byte16_bridge_dp #(.NUM_CMP(NUM_CMP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrByte   (cpuWrData),
    .regVals  ({cmpVal, capVal, cntVal}),
    .rdData   (cpuRdData),
    .cntWrEn  (cntWrEn),
    .cmpWrEn  (cmpWrEn),
    .wrData16 (wrData16)
  );

  logic anyStb;
  assign anyStb = cntWrEn || (|cmpWrEn);

  AST_HIGH_WR_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $past(cpuWr && cpuAddr[0]) |-> !anyStb);  // R2
  AST_COMMIT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> $past(cpuWr && !cpuAddr[0] && (cpuAddr <= ADDR_W'(LAST_ADDR))));  // R3
  AST_COMMIT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> (wrData16[7:0] == $past(cpuWrData)));  // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmpWrEn, cntWrEn}));  // R4
  AST_CAP_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    $past(cpuWr && (cpuAddr == ADDR_W'(2))) |-> !anyStb);  // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(cpuRd && !cpuWr && (cpuAddr > ADDR_W'(LAST_ADDR))) |-> (cpuRdData == 8'h00));  // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cpuRd && !cpuWr) |-> $stable(cpuRdData));  // R11
endmodule

// File: tb/byte16_bridge_tb.sv
`timescale 1ns/1ps
module byte16_bridge_tb;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic cpuWr = 1'b0;
  logic cpuRd = 1'b0;
  logic [7:0] cpuRdData;
  logic [15:0] cntTb;
  logic [15:0] capVal = 16'h0000;
  logic [16*NC-1:0] cmpTb;
  logic cntWrEn;
  logic [NC-1:0] cmpWrEn;
  logic [15:0] wrData16;
  logic run = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [15:0] lastSeen;

  always #2 clk = ~clk;

  byte16_bridge #(.ADDR_W(8), .NUM_CMP(NC)) u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuRdData(cpuRdData),
    .cntVal(cntTb), .capVal(capVal), .cmpVal(cmpTb),
    .cntWrEn(cntWrEn), .cmpWrEn(cmpWrEn), .wrData16(wrData16)
  );

  // peripheral models driven by the bridge's strobes
  always @(posedge clk) begin
    if (!rstN) begin
      cntTb <= 16'h0000;
      cmpTb <= {16'h5E6F, 16'h3C4D, 16'h1A2B};
    end else begin
      if (cntWrEn)  cntTb <= wrData16;
      else if (run) cntTb <= cntTb + 16'd1;
      for (int k = 0; k < NC; k++) if (cmpWrEn[k]) cmpTb[k*16 +: 16] <= wrData16;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] stb();
    return {cmpWrEn, cntWrEn};
  endfunction

  task automatic busWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1;
    lastSeen = cntTb;
    @(negedge clk);
    cpuRd = 1'b0;
    d = cpuRdData;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdData", {8'h0, cpuRdData}, 16'h0000);
    chk("R1 strobes", {12'h0, stb()}, 16'h0000);
    busRd(8'd1, d);
    chk("R1 holding byte", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_cntWrite();
    busWr(8'd1, 8'hAB);
    chk("R2 no strobe on high write", {12'h0, stb()}, 16'h0000);
    busWr(8'd0, 8'hCD);
    chk("R3 cnt strobe", {12'h0, stb()}, 16'h0001);
    chk("R3 wrData16", wrData16, 16'hABCD);
    @(negedge clk);
    chk("R3 single pulse", {12'h0, stb()}, 16'h0000);
    chk("R3 counter loaded", cntTb, 16'hABCD);
  endtask

  task automatic t_cmpShared();
    logic [7:0] d;
    busWr(8'd5, 8'h11);          // compare0 high
    busWr(8'd6, 8'h22);          // compare1 low
    chk("R4 R8 cmp1 strobe", {12'h0, stb()}, 16'h0004);
    chk("R8 shared holding in commit", wrData16, 16'h1122);
    busRd(8'd7, d);
    chk("R7 cmp1 high direct", {8'h0, d}, 16'h0011);
    busRd(8'd6, d);
    chk("R7 cmp1 low", {8'h0, d}, 16'h0022);
  endtask

  task automatic t_cmpNoSnap();
    logic [7:0] d;
    busWr(8'd3, 8'h77);          // capture high: holding only
    chk("R2 capture high no strobe", {12'h0, stb()}, 16'h0000);
    busRd(8'd4, d);
    chk("R7 cmp0 low", {8'h0, d}, 16'h002B);
    busRd(8'd9, d);
    chk("R7 cmp2 high direct", {8'h0, d}, 16'h005E);
    busRd(8'd1, d);
    chk("R7 holding untouched", {8'h0, d}, 16'h0077);
  endtask

  task automatic t_capRead();
    logic [7:0] d;
    capVal = 16'h9876;
    busRd(8'd2, d);
    chk("R5 cap low", {8'h0, d}, 16'h0076);
    capVal = 16'h0000;
    busRd(8'd3, d);
    chk("R6 cap high from holding", {8'h0, d}, 16'h0098);
    busRd(8'd1, d);
    chk("R8 shared via counter high", {8'h0, d}, 16'h0098);
  endtask

  task automatic t_capWrite();
    logic [7:0] d;
    busWr(8'd2, 8'h55);
    chk("R9 no strobe", {12'h0, stb()}, 16'h0000);
    busRd(8'd1, d);
    chk("R9 holding kept", {8'h0, d}, 16'h0098);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    busWr(8'd10, 8'h66);
    chk("R10 write ignored", {12'h0, stb()}, 16'h0000);
    busWr(8'd11, 8'h66);
    chk("R10 high write ignored", {12'h0, stb()}, 16'h0000);
    busRd(8'd200, d);
    chk("R10 read zero", {8'h0, d}, 16'h0000);
    busRd(8'd1, d);
    chk("R10 holding kept", {8'h0, d}, 16'h0098);
  endtask

  task automatic t_simul();
    logic [7:0] d;
    busRd(8'd4, d);
    chk("R11 setup", {8'h0, d}, 16'h002B);
    @(negedge clk);
    cpuAddr = 8'd1; cpuWrData = 8'h3C; cpuWr = 1'b1; cpuRd = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0; cpuRd = 1'b0;
    chk("R11 read ignored", {8'h0, cpuRdData}, 16'h002B);
    busRd(8'd1, d);
    chk("R11 write performed", {8'h0, d}, 16'h003C);
  endtask

  task automatic t_torn();
    logic [7:0] lo, hi;
    logic [15:0] atLow;
    busWr(8'd1, 8'h12);
    busWr(8'd0, 8'hFF);
    run = 1'b1;                 // counter steps from the next edge on
    busRd(8'd0, lo);
    atLow = lastSeen;
    busRd(8'd1, hi);
    chk("R12 snapshot value", atLow, 16'h12FF);
    chk("R12 low byte", {8'h0, lo}, {8'h0, atLow[7:0]});
    chk("R12 high byte not torn", {8'h0, hi}, {8'h0, atLow[15:8]});
    chk("R12 counter carried", {8'h0, cntTb[15:8]}, 16'h0013);
    run = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_cntWrite();
    t_cmpShared();
    t_cmpNoSnap();
    t_capRead();
    t_capWrite();
    t_unmapped();
    t_simul();
    t_torn();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule